// File: doc/BRIEF.md
# Luma Peaking Enhancer with Coring

This block sharpens a stream of 8-bit luminance samples. Each accepted sample enters a five-sample history. Two shaping filters read that history at the same time. The first reacts to the finest detail: it takes twice the middle sample and subtracts its two immediate neighbours. The second reacts to somewhat coarser detail: it takes twice the middle sample and subtracts the two outermost samples. Each filter output is scaled by its own 4-bit gain code. Code 4 means no change, larger codes add detail and smaller codes remove it. The two scaled terms are summed into one correction.

A shared coring stage then shaves a small dead zone off the correction, so that gentle grey ramps stay smooth. Coring can be turned off. The correction is added to the untouched middle sample, and the result is clipped to the 8-bit range.

The design is a three-register pipeline with a fixed latency. Samples may arrive with gaps between them. The history advances only on strobed samples. The gain codes and the coring enable are captured together with each sample.

Top module: `luma_sharpener`

## Requirements
- R1: While reset is high at a clock edge, `pix_out_vld` and `pix_out` become 0 after that edge, and the history is cleared to zeros.
- R2: `pix_out_vld` is high after clock edge k+2 exactly when `pix_in_vld` was high at edge k, so every accepted sample yields exactly one result.
- R3: The history shifts only on edges where `pix_in_vld` is high. The result produced for the n-th accepted sample is centred on the sample accepted two strobes earlier (zero before the history fills).
- R4: The fine-detail term is `2*c - p1 - n1`, where c is the middle history sample and p1/n1 are its direct neighbours.
- R5: The coarse-detail term is `2*c - p2 - n2`, where p2/n2 are the oldest and newest of the five history samples.
- R6: Each term is weighted as `floor(term * (code - 4) / 4)`, using signed arithmetic with an arithmetic right shift. With both codes at 4 the result equals the middle sample.
- R7: With `core_on` = 1, a summed correction of magnitude at most 2 becomes 0. A larger magnitude is reduced by 2 toward zero.
- R8: With `core_on` = 0, the summed correction is added unchanged.
- R9: The middle sample plus the correction is clipped to 0 below and to 255 above.
- R10: `gain_fine`, `gain_coarse` and `core_on` are sampled on the same edge as the strobed sample, and they govern the result emitted for that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in_vld | input | 1 | Input sample strobe |
| pix_in | input | 8 | Unsigned luma sample |
| gain_fine | input | 4 | Weight code of the fine-detail filter, 4 = neutral |
| gain_coarse | input | 4 | Weight code of the coarse-detail filter, 4 = neutral |
| core_on | input | 1 | 1 enables the coring dead zone |
| pix_out_vld | output | 1 | Result strobe |
| pix_out | output | 8 | Enhanced luma sample |

## Verification
The assertions assume that reset is held for at least one clock edge before streaming starts. They also assume that `pix_in`, the gain codes and `core_on` are known values on every strobed edge. Nothing is assumed about the gaps between strobes, or about codes changing between one sample and the next. The stimulus meets these assumptions:
- It drives every input at the falling edge.
- It keeps the strobe low throughout reset.
- It sweeps the codes across their whole range, including per-sample changes and strobe gaps.
- It feeds full-scale alternations, so the clip limits are reached.

// File: rtl/lpk_pkg.sv
package lpk_pkg;

    // Which detail filter a branch instance implements
    typedef enum logic [0:0] {
        KERN_FINE   = 1'b0,
        KERN_COARSE = 1'b1
    } kern_e;

    // History length shared by both kernels; centre index follows from it
    localparam int HIST_LEN = 5;
    localparam int HIST_MID = HIST_LEN / 2;

endpackage

// File: rtl/lpk_tapline.sv
module lpk_tapline #(
    parameter int DW  = 8,
    parameter int LEN = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv,
    input  logic [DW-1:0]           din,
    output logic [LEN-1:0][DW-1:0]  taps
);

    // Index 0 holds the newest sample
    for (genvar i = 0; i < LEN; i++) begin : g_tap
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)      taps[i] <= '0;
                else if (adv) taps[i] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)      taps[i] <= '0;
                else if (adv) taps[i] <= taps[i-1];
            end
        end
    end

    // R3: history frozen on non-strobed edges
    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(taps));

    // R1: reset empties the history
    assert_clear_on_reset_R1: assert property (@(posedge clk)
        rst |=> (taps == '0));

endmodule

// File: rtl/lpk_branch.sv
module lpk_branch
    import lpk_pkg::*;
#(
    parameter int    DW   = 8,
    parameter kern_e KIND = KERN_FINE
) (
    input  logic [HIST_LEN-1:0][DW-1:0] taps,
    output logic signed [DW+2:0]        fout
);

    localparam int OW = DW + 3;

    logic signed [OW-1:0] centre2;
    logic signed [OW-1:0] side_a;
    logic signed [OW-1:0] side_b;

    assign centre2 = signed'({2'b00, taps[HIST_MID], 1'b0});

    if (KIND == KERN_FINE) begin : g_fine
        assign side_a = signed'({3'b000, taps[HIST_MID-1]});
        assign side_b = signed'({3'b000, taps[HIST_MID+1]});
    end else begin : g_coarse
        assign side_a = signed'({3'b000, taps[0]});
        assign side_b = signed'({3'b000, taps[HIST_LEN-1]});
    end

    assign fout = centre2 - side_a - side_b;

endmodule

// File: rtl/lpk_weight.sv
module lpk_weight #(
    parameter int FW      = 11,
    parameter int GW      = 4,
    parameter int NEUTRAL = 4,
    parameter int SHIFT   = 2
) (
    input  logic signed [FW-1:0]      term,
    input  logic [GW-1:0]             code,
    output logic signed [FW+GW+1:0]   scaled
);

    localparam int KW = GW + 2;
    localparam int PW = FW + GW + 2;
    localparam logic signed [KW-1:0] NEU = KW'(NEUTRAL);

    logic signed [KW-1:0] factor;
    logic signed [PW-1:0] prod;

    assign factor = signed'({2'b00, code}) - NEU;
    assign prod   = PW'(term) * PW'(factor);
    assign scaled = prod >>> SHIFT;

endmodule

// File: rtl/lpk_coring.sv
module lpk_coring #(
    parameter int SW = 18,
    parameter int TH = 2
) (
    input  logic                 en,
    input  logic signed [SW-1:0] corr_in,
    output logic signed [SW-1:0] corr_out
);

    localparam logic signed [SW-1:0] POS_TH = SW'(TH);
    localparam logic signed [SW-1:0] NEG_TH = -SW'(TH);

    always_comb begin
        if (!en)                    corr_out = corr_in;
        else if (corr_in > POS_TH)  corr_out = corr_in - POS_TH;
        else if (corr_in < NEG_TH)  corr_out = corr_in + POS_TH;
        else                        corr_out = '0;
    end

endmodule

// File: rtl/luma_sharpener.sv
module luma_sharpener
    import lpk_pkg::*;
#(
    parameter int DW      = 8,
    parameter int GW      = 4,
    parameter int NEUTRAL = 4,
    parameter int GSHIFT  = 2,
    parameter int CORE_TH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_in_vld,
    input  logic [DW-1:0] pix_in,
    input  logic [GW-1:0] gain_fine,
    input  logic [GW-1:0] gain_coarse,
    input  logic          core_on,
    output logic          pix_out_vld,
    output logic [DW-1:0] pix_out
);

    localparam int FW = DW + 3;
    localparam int PW = FW + GW + 2;
    localparam int SW = PW + 1;
    localparam int TW = SW + 1;
    localparam logic signed [TW-1:0] MAXV = TW'((1 << DW) - 1);

    // Stage 1: history and captured controls
    logic [HIST_LEN-1:0][DW-1:0] taps;
    logic          s1_vld;
    logic [GW-1:0] s1_gf, s1_gc;
    logic          s1_cor;

    lpk_tapline #(.DW(DW), .LEN(HIST_LEN)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .adv  (pix_in_vld),
        .din  (pix_in),
        .taps (taps)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1_gf  <= GW'(NEUTRAL);
            s1_gc  <= GW'(NEUTRAL);
            s1_cor <= 1'b0;
        end else begin
            s1_vld <= pix_in_vld;
            if (pix_in_vld) begin
                s1_gf  <= gain_fine;
                s1_gc  <= gain_coarse;
                s1_cor <= core_on;
            end
        end
    end

    // Filters and weighting
    logic signed [FW-1:0] term_f, term_c;
    logic signed [PW-1:0] wt_f, wt_c;
    logic signed [SW-1:0] corr_sum;

    lpk_branch #(.DW(DW), .KIND(KERN_FINE)) u_fine (
        .taps (taps), .fout (term_f)
    );
    lpk_branch #(.DW(DW), .KIND(KERN_COARSE)) u_coarse (
        .taps (taps), .fout (term_c)
    );

    lpk_weight #(.FW(FW), .GW(GW), .NEUTRAL(NEUTRAL), .SHIFT(GSHIFT)) u_wf (
        .term (term_f), .code (s1_gf), .scaled (wt_f)
    );
    lpk_weight #(.FW(FW), .GW(GW), .NEUTRAL(NEUTRAL), .SHIFT(GSHIFT)) u_wc (
        .term (term_c), .code (s1_gc), .scaled (wt_c)
    );

    assign corr_sum = SW'(wt_f) + SW'(wt_c);

    // Stage 2: summed correction and centre sample
    logic                 s2_vld;
    logic signed [SW-1:0] s2_sum;
    logic [DW-1:0]        s2_ctr;
    logic                 s2_cor;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld <= 1'b0;
            s2_sum <= '0;
            s2_ctr <= '0;
            s2_cor <= 1'b0;
        end else begin
            s2_vld <= s1_vld;
            if (s1_vld) begin
                s2_sum <= corr_sum;
                s2_ctr <= taps[HIST_MID];
                s2_cor <= s1_cor;
            end
        end
    end

    // Coring, add-back and clip
    logic signed [SW-1:0] cored;
    logic signed [TW-1:0] ctr_ext;
    logic signed [TW-1:0] total;
    logic signed [TW-1:0] raw_sum;
    logic [DW-1:0]        clipped;

    lpk_coring #(.SW(SW), .TH(CORE_TH)) u_core (
        .en (s2_cor), .corr_in (s2_sum), .corr_out (cored)
    );

    assign ctr_ext = signed'({{(TW-DW){1'b0}}, s2_ctr});
    assign total   = ctr_ext + TW'(cored);
    assign raw_sum = ctr_ext + TW'(s2_sum);

    always_comb begin
        if (total < 0)          clipped = '0;
        else if (total > MAXV)  clipped = '1;
        else                    clipped = total[DW-1:0];
    end

    // Stage 3: output register
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out_vld <= 1'b0;
            pix_out     <= '0;
        end else begin
            pix_out_vld <= s2_vld;
            if (s2_vld) pix_out <= clipped;
        end
    end

    // R1: reset state of the outputs
    assert_out_reset_R1: assert property (@(posedge clk)
        rst |=> (!pix_out_vld && pix_out == '0));

    // R2: strobe travels one stage per clock
    assert_strobe_s2_R2: assert property (@(posedge clk) disable iff (rst)
        s1_vld |=> s2_vld);
    assert_strobe_out_R2: assert property (@(posedge clk) disable iff (rst)
        s2_vld |=> pix_out_vld);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !s2_vld |=> !pix_out_vld);

    // R6: neutral codes give no correction
    assert_neutral_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_gf == GW'(NEUTRAL) && s1_gc == GW'(NEUTRAL)) |=> (s2_sum == '0));

    // R7: dead zone returns the centre unchanged
    assert_dead_zone_R7: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && s2_cor && s2_sum <= SW'(CORE_TH) && s2_sum >= -SW'(CORE_TH))
        |=> (pix_out == $past(s2_ctr)));

    // R9: clip limits
    assert_sat_high_R9: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && !s2_cor && raw_sum > MAXV) |=> (pix_out == '1));
    assert_sat_low_R9: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && !s2_cor && raw_sum < 0) |=> (pix_out == '0));

endmodule

// File: tb/sim_luma_sharpener.sv
module sim_luma_sharpener;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_in_vld = 1'b0;
    logic [7:0] pix_in = '0;
    logic [3:0] gain_fine = 4'd4;
    logic [3:0] gain_coarse = 4'd4;
    logic       core_on = 1'b0;
    logic       pix_out_vld;
    logic [7:0] pix_out;

    luma_sharpener u0 (
        .clk         (clk),
        .rst         (rst),
        .pix_in_vld  (pix_in_vld),
        .pix_in      (pix_in),
        .gain_fine   (gain_fine),
        .gain_coarse (gain_coarse),
        .core_on     (core_on),
        .pix_out_vld (pix_out_vld),
        .pix_out     (pix_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    value;
        int    due;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   hist[5];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Independent model of the requirements
    function automatic int model(input int gf, input int gc, input bit cor);
        int tf, tc, corr, tot;
        tf   = 2*hist[2] - hist[1] - hist[3];          // R4
        tc   = 2*hist[2] - hist[0] - hist[4];          // R5
        corr = ((tf * (gf - 4)) >>> 2) + ((tc * (gc - 4)) >>> 2);  // R6
        if (cor) begin                                  // R7
            if (corr > 2)       corr = corr - 2;
            else if (corr < -2) corr = corr + 2;
            else                corr = 0;
        end                                             // R8 when cor == 0
        tot = hist[2] + corr;
        if (tot < 0)   tot = 0;                         // R9
        if (tot > 255) tot = 255;
        return tot;
    endfunction

    task automatic send(input int v, input int gf, input int gc, input bit cor, input string tag);
        exp_t e;
        @(negedge clk);
        pix_in_vld  = 1'b1;
        pix_in      = 8'(v);
        gain_fine   = 4'(gf);
        gain_coarse = 4'(gc);
        core_on     = cor;
        for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = v;
        e.value = model(gf, gc, cor);
        e.due   = cyc + 1 + 2;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_in_vld = 1'b0;
            pix_in     = 8'hA5;
            gain_fine  = 4'd15;
            core_on    = 1'b0;
        end
    endtask

    // Monitor: pops expectations as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && pix_out_vld) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected result", int'(pix_out), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(pix_out) == e.value, e.tag, int'(pix_out), e.value);
                    check(cyc == e.due, "R2 latency", cyc, e.due);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) hist[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pix_out_vld == 1'b0, "R1 reset vld", int'(pix_out_vld), 0);
        check(pix_out == 8'd0, "R1 reset data", int'(pix_out), 0);
        rst = 1'b0;

        // R6 neutral ramp: output tracks delayed input
        for (int i = 0; i < 12; i++) send(i * 20, 4, 4, 1'b1, "R6 neutral ramp");
        // R4 fine-detail boost on a step
        for (int i = 0; i < 10; i++) send((i < 5) ? 40 : 200, 12, 4, 1'b0, "R4 fine step");
        // R5 coarse-detail boost on impulses
        for (int i = 0; i < 12; i++) send((i % 6 == 0) ? 180 : 60, 4, 15, 1'b0, "R5 coarse impulse");
        // R6 attenuation codes below neutral
        for (int i = 0; i < 10; i++) send((i % 2) ? 150 : 90, 0, 2, 1'b0, "R6 attenuate");
        // R7 / R8 small ripple with and without coring
        for (int i = 0; i < 12; i++) send(100 + (i % 3), 5, 6, 1'b1, "R7 coring small");
        for (int i = 0; i < 12; i++) send(100 + (i % 3), 5, 6, 1'b0, "R8 coring off");
        for (int i = 0; i < 10; i++) send(120 + 3 * (i % 4), 9, 7, 1'b1, "R7 coring shrink");
        // R9 full-scale alternation with maximum boost
        for (int i = 0; i < 12; i++) send((i % 2) ? 255 : 0, 15, 15, 1'b0, "R9 clip");
        for (int i = 0; i < 8; i++) send((i % 2) ? 250 : 5, 15, 15, 1'b1, "R9 clip cored");
        // R3 strobe gaps: idle inputs must not shift history
        for (int i = 0; i < 10; i++) begin
            send(30 + 17 * i, 10, 8, 1'b0, "R3 gapped");
            idle(i % 3 + 1);
        end
        // R10 per-sample control changes
        for (int i = 0; i < 16; i++) send((i * 37) % 256, i, 15 - i, i[0], "R10 per-sample codes");

        idle(6);
        check(exp_q.size() == 0, "R2 all results emitted", exp_q.size(), 0);
        check(pix_out_vld == 1'b0, "R2 strobe idle", int'(pix_out_vld), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule